// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the bus-facing register file of a multi-channel event timer. It holds three registers of its own: a read-only capability word, a global configuration register carrying the enable and legacy-routing bits, and a 64-bit free-running main counter. It also decodes one address window per channel. Channel writes go out as strobes carrying positioned data and a bit mask. Channel reads are fetched through a combinational index/select pair. Comparators, interrupt generation and routing sit outside the block. Its only link to interrupts is a status input that it reads back, and a clear strobe that it emits when software writes the status register.

Every register is 64 bits wide. The bus issues either 32-bit or 64-bit accesses. Address bit 2 picks the upper half of a register. A narrow access moves only that half, and a write merges into the old contents so that the other bits keep their value. The counter advances by one on each `tick_en` pulse while the global enable is set. While the enable is clear the counter stands still and software may load it.

A small controller sequences the bus responses. It has three states: IDLE, READ_RESP and WRITE_POST. An accepted read moves it to READ_RESP, an accepted channel or status write moves it to WRITE_POST, and any other cycle moves it to IDLE. These transitions are taken from every state, so back-to-back requests are served without gaps. Read data and write strobes appear exactly one cycle after the request.

Top module: `tmr_regif`

## Requirements
- R1: After reset, the counter and the configuration register are 0, and `bus_rvalid`, `ch_wr_valid` and `sts_clr_valid` are low.
- R2: The capability register at offset 0x000 reads bits [7:0]=0x01, bits [12:8]=NCH-1, bit 15=1 (legacy routing supported), bits [14:13] and [31:16]=0, and bits [63:32]=TICK_FS. Writes to it have no effect.
- R3: Address bit 2 selects the half of a register. A 32-bit read returns the selected half in bits [31:0] with bits [63:32] zero. A 64-bit read at a multiple of 8 returns the whole register.
- R4: The configuration register at offset 0x010 keeps only bit 0 (enable, output `glb_enable`) and bit 1 (legacy, output `glb_legacy`) from a write. All other bits read 0, and bits outside the addressed half keep their value.
- R5: While enable is 1, the counter (offset 0x0F0, output `cnt_value`) increments by one on every cycle with `tick_en` high, carrying across bit 32. While enable is 0, it holds its value.
- R6: Counter writes are merged into the addressed half only while enable is 0. While enable is 1 they are ignored. After enabling, counting resumes from the written value.
- R7: Channel n owns 0x100+0x20*n. A write to +0x00, +0x08 or +0x10 raises `ch_wr_valid` for exactly one cycle, the cycle after the request, with `ch_wr_idx`=n, `ch_wr_sel`=0/1/2 respectively, `ch_wr_data` holding the written half in place, and `ch_wr_mask` marking the written bits.
- R8: `ch_rd_idx`/`ch_rd_sel` follow the request address combinationally. A read of a channel register returns `ch_rd_data` as sampled in the request cycle.
- R9: Offsets with no register (channel index ≥ NCH, channel offset +0x18, and global offsets other than 0x000, 0x010, 0x020 and 0x0F0) read as 0. Writes to them change no register and raise no strobe.
- R10: The status register at 0x020 reads `irq_status` in bits [NCH-1:0]. Writing it raises `sts_clr_valid` for one cycle with `sts_clr_bits` equal to the written bits [NCH-1:0] of the low half, which is 0 for an upper-half write.
- R11: `bus_rvalid` is high exactly in the cycle after each accepted read, including when reads come on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance pulse |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 64 | Write data (32-bit access uses [31:0]) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 64 | Read data |
| cnt_value | output | 64 | Main counter |
| glb_enable | output | 1 | Global enable bit |
| glb_legacy | output | 1 | Legacy routing bit |
| irq_status | input | NCH | Per-channel interrupt status |
| sts_clr_valid | output | 1 | Status write strobe |
| sts_clr_bits | output | NCH | Bits written to status |
| ch_wr_valid | output | 1 | Channel register write strobe |
| ch_wr_idx | output | IDXW | Channel index of the write |
| ch_wr_sel | output | 2 | 0 config, 1 comparator, 2 route |
| ch_wr_data | output | 64 | Write data in register position |
| ch_wr_mask | output | 64 | Bits to update |
| ch_rd_idx | output | IDXW | Channel index being read |
| ch_rd_sel | output | 2 | Channel register being read |
| ch_rd_data | input | 64 | Channel register contents |

## Verification
The address decoder is swept over every channel index up to one past the last and over all four channel slots. Each sweep uses narrow lower-half, narrow upper-half and wide accesses, which separates correct window arithmetic and half masking from off-by-one index limits or swapped halves. The counter is loaded with a value just below a 32-bit boundary, counted across the carry, and then frozen. This tells a missing carry, counting while disabled, and writes slipping through while enabled apart. Back-to-back reads, status writes to each half, and writes to holes in the map show that response timing and "no effect" cases do not disturb neighbouring registers.

// File: rtl/tmr_regif_pkg.sv
package tmr_regif_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;

    localparam logic [ADDR_W-1:0] OFS_CAP = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CFG = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_STS = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_CNT = 12'h0F0;
    localparam logic [ADDR_W-1:0] CH_BASE = 12'h100;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CAP,
        RK_CFG,
        RK_STS,
        RK_CNT,
        RK_CHAN
    } reg_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE,
        FS_RDATA,
        FS_WPOST
    } fsm_state_e;

    function automatic logic [DATA_W-1:0] lane_mask(input logic upper, input logic wide);
        logic [DATA_W-1:0] m;
        if (upper)      m = {{(DATA_W/2){1'b1}}, {(DATA_W/2){1'b0}}};
        else if (wide)  m = '1;
        else            m = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};
        return m;
    endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
    import tmr_regif_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int IDXW = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_kind_e         kind_o,
    output logic [IDXW-1:0]   ch_idx_o,
    output logic [1:0]        ch_sel_o
);

    localparam int FULLW = ADDR_W - 5;
    localparam logic [FULLW-1:0] NCH_W = FULLW'(NCH);

    logic [ADDR_W-1:0] a8;
    logic [ADDR_W-1:0] off;
    logic [FULLW-1:0]  idx_full;

    always_comb begin
        a8       = {addr_i[ADDR_W-1:3], 3'b000};
        off      = addr_i - CH_BASE;
        idx_full = off[ADDR_W-1:5];
        ch_idx_o = idx_full[IDXW-1:0];
        ch_sel_o = off[4:3];
        kind_o   = RK_NONE;
        if (addr_i[ADDR_W-1:8] != '0) begin
            if (idx_full < NCH_W && ch_sel_o != 2'd3)
                kind_o = RK_CHAN;
        end else begin
            unique case (a8)
                OFS_CAP: kind_o = RK_CAP;
                OFS_CFG: kind_o = RK_CFG;
                OFS_STS: kind_o = RK_STS;
                OFS_CNT: kind_o = RK_CNT;
                default: kind_o = RK_NONE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_cfg_reg.sv
module tmr_cfg_reg
    import tmr_regif_pkg::*;
#(
    parameter logic [DATA_W-1:0] WMASK = 64'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wmask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cfg_o
);

    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] eff;

    always_comb eff = wmask_i & WMASK;

    always_ff @(posedge clk) begin
        if (!rst_n)    cfg_q <= '0;
        else if (wr_i) cfg_q <= (cfg_q & ~eff) | (wdata_i & eff);
    end

    assign cfg_o = cfg_q;

    // R4: no write, no change
    p_cfg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_q));

    // R4: bits outside the addressed half are untouched
    p_cfg_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> ((cfg_q & ~$past(wmask_i)) == ($past(cfg_q) & ~$past(wmask_i))));

endmodule

// File: rtl/tmr_main_counter.sv
module tmr_main_counter
    import tmr_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wmask_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] cnt_o
);

    logic [DATA_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!en_i && wr_i)
            cnt_q <= (cnt_q & ~wmask_i) | (wdata_i & wmask_i);
        else if (en_i && tick_i)
            cnt_q <= cnt_q + DATA_W'(1);
    end

    assign cnt_o = cnt_q;

    // R5: frozen while disabled and not written
    p_cnt_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !wr_i) |=> $stable(cnt_q));

    // R5: one step per tick while enabled
    p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && tick_i) |=> (cnt_q == $past(cnt_q) + DATA_W'(1)));

    // R6: writes while enabled do not disturb the count
    p_cnt_wr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !tick_i) |=> $stable(cnt_q));

    // R6: load while disabled lands in the addressed bits
    p_cnt_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && wr_i) |=> ((cnt_q & $past(wmask_i)) == ($past(wdata_i) & $past(wmask_i))));

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_regif_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int TICK_FS = 10_000_000,
    parameter int IDXW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_rvalid,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] cnt_value,
    output logic              glb_enable,
    output logic              glb_legacy,
    input  logic [NCH-1:0]    irq_status,
    output logic              sts_clr_valid,
    output logic [NCH-1:0]    sts_clr_bits,
    output logic              ch_wr_valid,
    output logic [IDXW-1:0]   ch_wr_idx,
    output logic [1:0]        ch_wr_sel,
    output logic [DATA_W-1:0] ch_wr_data,
    output logic [DATA_W-1:0] ch_wr_mask,
    output logic [IDXW-1:0]   ch_rd_idx,
    output logic [1:0]        ch_rd_sel,
    input  logic [DATA_W-1:0] ch_rd_data
);

    localparam int HALF = DATA_W / 2;
    localparam logic [DATA_W-1:0] CFG_WMASK = 64'h3;
    localparam logic [DATA_W-1:0] CAP_WORD =
        (DATA_W'(TICK_FS) << HALF) | (DATA_W'(1) << 15) |
        (DATA_W'(NCH - 1) << 8) | DATA_W'(8'h01);

    reg_kind_e         kind;
    logic [IDXW-1:0]   dec_idx;
    logic [1:0]        dec_sel;
    logic              upper;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] wdata_sh;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_half;
    logic [DATA_W-1:0] cfg_word;
    logic              rd_go, wr_go;

    fsm_state_e        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              chw_v_q, sts_v_q;
    logic [IDXW-1:0]   chw_idx_q;
    logic [1:0]        chw_sel_q;
    logic [DATA_W-1:0] chw_data_q, chw_mask_q;
    logic [NCH-1:0]    sts_bits_q;

    tmr_addr_decode #(.NCH(NCH), .IDXW(IDXW)) u_dec (
        .addr_i   (bus_addr),
        .kind_o   (kind),
        .ch_idx_o (dec_idx),
        .ch_sel_o (dec_sel)
    );

    always_comb begin
        rd_go    = bus_req && !bus_we;
        wr_go    = bus_req && bus_we;
        upper    = bus_addr[2];
        wmask    = lane_mask(upper, bus_wide);
        wdata_sh = upper ? {bus_wdata[HALF-1:0], {HALF{1'b0}}} : bus_wdata;
    end

    tmr_cfg_reg #(.WMASK(CFG_WMASK)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_go && kind == RK_CFG),
        .wmask_i (wmask),
        .wdata_i (wdata_sh),
        .cfg_o   (cfg_word)
    );

    assign glb_enable = cfg_word[0];
    assign glb_legacy = cfg_word[1];

    tmr_main_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (glb_enable),
        .tick_i  (tick_en),
        .wr_i    (wr_go && kind == RK_CNT),
        .wmask_i (wmask),
        .wdata_i (wdata_sh),
        .cnt_o   (cnt_value)
    );

    // Read word selection and half extraction
    always_comb begin
        unique case (kind)
            RK_CAP:  rd_word = CAP_WORD;
            RK_CFG:  rd_word = cfg_word;
            RK_STS:  rd_word = DATA_W'(irq_status);
            RK_CNT:  rd_word = cnt_value;
            RK_CHAN: rd_word = ch_rd_data;
            default: rd_word = '0;
        endcase
        if (upper)          rd_half = {{HALF{1'b0}}, rd_word[DATA_W-1:HALF]};
        else if (bus_wide)  rd_half = rd_word;
        else                rd_half = {{HALF{1'b0}}, rd_word[HALF-1:0]};
    end

    assign ch_rd_idx = dec_idx;
    assign ch_rd_sel = dec_sel;

    // Next-state logic
    always_comb begin
        state_d = FS_IDLE;
        unique case (state_q)
            FS_IDLE, FS_RDATA, FS_WPOST: begin
                if (rd_go)
                    state_d = FS_RDATA;
                else if (wr_go && (kind == RK_CHAN || kind == RK_STS))
                    state_d = FS_WPOST;
                else
                    state_d = FS_IDLE;
            end
            default: state_d = FS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FS_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            chw_v_q    <= 1'b0;
            chw_idx_q  <= '0;
            chw_sel_q  <= '0;
            chw_data_q <= '0;
            chw_mask_q <= '0;
            sts_v_q    <= 1'b0;
            sts_bits_q <= '0;
        end else begin
            if (rd_go) rdata_q <= rd_half;
            chw_v_q <= wr_go && kind == RK_CHAN;
            if (wr_go && kind == RK_CHAN) begin
                chw_idx_q  <= dec_idx;
                chw_sel_q  <= dec_sel;
                chw_data_q <= wdata_sh & wmask;
                chw_mask_q <= wmask;
            end
            sts_v_q <= wr_go && kind == RK_STS;
            if (wr_go && kind == RK_STS)
                sts_bits_q <= wdata_sh[NCH-1:0] & wmask[NCH-1:0];
        end
    end

    assign bus_rvalid    = (state_q == FS_RDATA);
    assign bus_rdata     = rdata_q;
    assign ch_wr_valid   = chw_v_q;
    assign ch_wr_idx     = chw_idx_q;
    assign ch_wr_sel     = chw_sel_q;
    assign ch_wr_data    = chw_data_q;
    assign ch_wr_mask    = chw_mask_q;
    assign sts_clr_valid = sts_v_q;
    assign sts_clr_bits  = sts_bits_q;

    // R11: a response follows only an accepted read
    p_rvalid_after_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_req && !bus_we));

    // R7: a channel strobe names an implemented channel and a defined slot
    p_chwr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ch_wr_valid |-> (32'(ch_wr_idx) < NCH && ch_wr_sel != 2'd3));

    // R7: strobe lives in the post-write state
    p_chwr_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_wr_valid || sts_clr_valid) |-> state_q == FS_WPOST);

    // R10: at most one kind of response per cycle
    p_one_response_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_rvalid, ch_wr_valid, sts_clr_valid}));

endmodule

// File: tb/tmr_regif_test.sv
module tmr_regif_test;
    localparam int CLK_P   = 10;
    localparam int NCH     = 3;
    localparam int IDXW    = 2;
    localparam int TICK_FS = 10_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b0;
    logic bus_req = 1'b0, bus_we = 1'b0, bus_wide = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic bus_rvalid;
    logic [63:0] bus_rdata, cnt_value;
    logic glb_enable, glb_legacy;
    logic [NCH-1:0] irq_status = 3'b101;
    logic sts_clr_valid;
    logic [NCH-1:0] sts_clr_bits;
    logic ch_wr_valid;
    logic [IDXW-1:0] ch_wr_idx, ch_rd_idx;
    logic [1:0] ch_wr_sel, ch_rd_sel;
    logic [63:0] ch_wr_data, ch_wr_mask, ch_rd_data;

    int total = 0;
    int bad = 0;

    always #(CLK_P/2) clk = ~clk;

    assign ch_rd_data = {16'hC0DE, 6'd0, ch_rd_idx, 6'd0, ch_rd_sel,
                         24'h5A5A00, 4'd0, ch_rd_idx, ch_rd_sel};

    tmr_regif #(.NCH(NCH), .TICK_FS(TICK_FS)) uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .cnt_value(cnt_value), .glb_enable(glb_enable), .glb_legacy(glb_legacy),
        .irq_status(irq_status), .sts_clr_valid(sts_clr_valid),
        .sts_clr_bits(sts_clr_bits), .ch_wr_valid(ch_wr_valid),
        .ch_wr_idx(ch_wr_idx), .ch_wr_sel(ch_wr_sel), .ch_wr_data(ch_wr_data),
        .ch_wr_mask(ch_wr_mask), .ch_rd_idx(ch_rd_idx), .ch_rd_sel(ch_rd_sel),
        .ch_rd_data(ch_rd_data)
    );

    // captured after each write
    logic w_chv, w_stv;
    logic [IDXW-1:0] w_idx;
    logic [1:0] w_sel;
    logic [63:0] w_data, w_mask;
    logic [NCH-1:0] w_sts;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic w, input logic [63:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_wide = w; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        w_chv = ch_wr_valid; w_idx = ch_wr_idx; w_sel = ch_wr_sel;
        w_data = ch_wr_data; w_mask = ch_wr_mask;
        w_stv = sts_clr_valid; w_sts = sts_clr_bits;
        @(negedge clk);
        bus_req = 0; bus_we = 0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic w, output logic [63:0] d);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_wide = w; bus_addr = a;
        @(posedge clk); #1;
        chk("R11 rvalid after read", 64'(bus_rvalid), 64'd1);
        d = bus_rdata;
        @(negedge clk);
        bus_req = 0;
    endtask

    function automatic logic [63:0] chmodel(input int n, input int s);
        logic [1:0] i2 = 2'(n);
        logic [1:0] s2 = 2'(s);
        return {16'hC0DE, 6'd0, i2, 6'd0, s2, 24'h5A5A00, 4'd0, i2, s2};
    endfunction

    initial begin
        #(CLK_P * 100000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] rd, cap, cntw;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        // R1 reset state
        chk("R1 counter", cnt_value, 64'd0);
        chk("R1 enable", 64'(glb_enable), 0);
        chk("R1 legacy", 64'(glb_legacy), 0);
        chk("R1 strobes", 64'({bus_rvalid, ch_wr_valid, sts_clr_valid}), 0);
        do_read(12'h010, 1, rd); chk("R1 config", rd, 0);

        // R2 / R3 capability
        cap = (64'(TICK_FS) << 32) | (64'd1 << 15) | (64'(NCH-1) << 8) | 64'h01;
        do_read(12'h000, 1, rd); chk("R2 cap wide", rd, cap);
        do_read(12'h000, 0, rd); chk("R3 cap low half", rd, {32'd0, cap[31:0]});
        do_read(12'h004, 0, rd); chk("R3 cap high half", rd, {32'd0, cap[63:32]});
        do_write(12'h000, 1, '1);
        do_read(12'h000, 1, rd); chk("R2 cap write ignored", rd, cap);

        // R4 config
        do_write(12'h010, 1, '1);
        do_read(12'h010, 1, rd); chk("R4 cfg masked", rd, 64'h3);
        chk("R4 enable out", 64'(glb_enable), 1);
        chk("R4 legacy out", 64'(glb_legacy), 1);
        do_write(12'h014, 0, 64'hFFFF_FFFF);
        do_read(12'h010, 1, rd); chk("R4 upper write", rd, 64'h3);
        do_write(12'h010, 0, 64'h2);
        do_read(12'h010, 1, rd); chk("R4 legacy only", rd, 64'h2);
        chk("R4 enable off", 64'(glb_enable), 0);
        do_write(12'h010, 0, 64'h0);
        chk("R5 no count while off", cnt_value, 0);

        // R6 load halves while disabled
        do_write(12'h0F0, 0, 64'hFFFF_FFF0);
        do_write(12'h0F4, 0, 64'h1);
        cntw = 64'h1_FFFF_FFF0;
        do_read(12'h0F0, 1, rd); chk("R6 load wide read", rd, cntw);
        do_read(12'h0F4, 0, rd); chk("R3 counter high half", rd, 64'h1);
        // ticks while disabled
        @(negedge clk); tick_en = 1; repeat (5) @(negedge clk); tick_en = 0;
        #1; chk("R5 hold while disabled", cnt_value, cntw);
        // enable and count across bit 32
        do_write(12'h010, 0, 64'h1);
        @(negedge clk); tick_en = 1; repeat (20) @(negedge clk); tick_en = 0;
        #1; chk("R5 count with carry", cnt_value, cntw + 20);
        do_write(12'h0F0, 1, 64'h0);
        do_read(12'h0F0, 1, rd); chk("R6 write while enabled ignored", rd, cntw + 20);
        do_write(12'h010, 0, 64'h0);
        @(negedge clk); tick_en = 1; repeat (4) @(negedge clk); tick_en = 0;
        #1; chk("R5 frozen after disable", cnt_value, cntw + 20);

        // R10 status
        do_read(12'h020, 1, rd); chk("R10 status read", rd, 64'h5);
        do_write(12'h020, 0, 64'h6);
        chk("R10 clr valid", 64'(w_stv), 1); chk("R10 clr bits", 64'(w_sts), 64'h6);
        chk("R10 no chan strobe", 64'(w_chv), 0);
        do_write(12'h024, 0, 64'h7);
        chk("R10 upper valid", 64'(w_stv), 1); chk("R10 upper bits", 64'(w_sts), 0);

        // R9 undefined global offsets
        do_write(12'h030, 1, '1);
        chk("R9 no strobe", 64'({w_chv, w_stv}), 0);
        do_read(12'h010, 1, rd); chk("R9 cfg untouched", rd, 0);
        do_read(12'h030, 1, rd); chk("R9 read 0x030", rd, 0);
        do_read(12'h008, 1, rd); chk("R9 read 0x008", rd, 0);
        do_read(12'h0F8, 1, rd); chk("R9 read 0x0F8", rd, 0);
        do_write(12'h0F8, 1, 64'h0);
        chk("R9 counter untouched", cnt_value, cntw + 20);

        // R7 / R8 / R9 channel sweep
        for (int n = 0; n <= NCH; n++) begin
            for (int s = 0; s < 4; s++) begin
                logic [11:0] a;
                logic ok;
                logic [63:0] d;
                a = 12'h100 + 12'(n * 32) + 12'(s * 8);
                ok = (n < NCH) && (s < 3);
                d = 64'hDEAD_0000 | 64'(n * 16 + s);
                do_write(a, 0, d);
                chk("R7 strobe valid", 64'(w_chv), 64'(ok));
                if (ok) begin
                    chk("R7 idx", 64'(w_idx), 64'(n));
                    chk("R7 sel", 64'(w_sel), 64'(s));
                    chk("R7 data low", w_data, {32'd0, d[31:0]});
                    chk("R7 mask low", w_mask, 64'h0000_0000_FFFF_FFFF);
                end
                do_write(a + 12'h4, 0, d);
                chk("R7 strobe valid upper", 64'(w_chv), 64'(ok));
                if (ok) begin
                    chk("R7 data upper", w_data, {d[31:0], 32'd0});
                    chk("R7 mask upper", w_mask, 64'hFFFF_FFFF_0000_0000);
                end
                do_write(a, 1, {32'h1234_5678, d[31:0]});
                if (ok) begin
                    chk("R7 data wide", w_data, {32'h1234_5678, d[31:0]});
                    chk("R7 mask wide", w_mask, '1);
                end
                do_read(a, 1, rd);
                chk("R8 R9 chan read wide", rd, ok ? chmodel(n, s) : 64'd0);
                do_read(a + 12'h4, 0, rd);
                chk("R8 chan read upper", rd, ok ? {32'd0, chmodel(n, s)} >> 32 : 64'd0);
            end
        end

        // R11 back-to-back reads
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_wide = 1; bus_addr = 12'h000;
        @(negedge clk);
        bus_addr = 12'h0F0;
        #1; chk("R11 first of pair", 64'(bus_rvalid), 1);
        chk("R11 first data", bus_rdata, cap);
        @(negedge clk);
        bus_req = 0;
        #1; chk("R11 second of pair", 64'(bus_rvalid), 1);
        chk("R11 second data", bus_rdata, cntw + 20);
        @(negedge clk); #1;
        chk("R11 idle drops", 64'(bus_rvalid), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule